// File: doc/BRIEF.md
# Programmable Prescaled Match Timer

A 32-bit up-counter with an 8-bit clock prescaler and a byte-wide register interface. Software programs a limit and a divide value, then starts the counter in one of two modes. In single-run mode the count climbs from zero to the limit and halts there. In repeating mode the count climbs to the limit, returns to zero and continues without end. Each time the count is at the limit on a counting step, a sticky match flag is set. The flag drives an interrupt line through a separate enable.

Software reads the live count through four capture bytes. Reading the lowest capture byte returns the live low byte and copies the whole count into a shadow. The three upper capture bytes return that shadow. A narrow bus that reads the bytes in rising address order therefore always gets one coherent value.

Top module: `match_timer`

## Requirements
- R1: After reset, mode (offset 0x0), interrupt enable (0x1), match flag (0x2), divide (0xC) and all capture bytes (0x8–0xB) read 0x00, and the limit bytes (0x4–0x7) read 0xFF.
- R2: Writing bit0 of offset 0x0 (bit1 clear) starts repeating mode. The count then advances by one per step from zero up to the limit, and the step taken at the limit returns it to zero.
- R3: Writing bit1 of offset 0x0 starts single-run mode. The step taken at the limit leaves the count at the limit, stops counting and clears bit1, so the mode register then reads 0x00.
- R4: The two mode bits never both read 1. Writing 0x03 selects single-run mode. Any write with either bit set zeroes the count and the prescaler. Writing 0x00 stops counting and leaves the count unchanged.
- R5: With divide value N at offset 0xC, a running counter takes one step every N+1 clocks. N=0 gives one step per clock.
- R6: The match flag (offset 0x2, bit0) is set on every step taken while the count equals the limit. It stays set until one of the clearing events of R7 or R8.
- R7: Writing a 1 to bit0 of offset 0x2 clears the flag. Writing 0 there leaves the flag unchanged.
- R8: The flag also clears on a write that starts either mode, or on a write to a limit byte (0x4 = least significant … 0x7) that changes its value. A limit write that leaves the value unchanged does not clear the flag. A step at the limit in the same cycle as a clearing event leaves the flag set.
- R9: The interrupt output equals the match flag ANDed with bit0 of offset 0x1, in every cycle.
- R10: A read of offset 0x8 returns the live low count byte and latches the full count. Reads of 0x9, 0xA and 0xB return bytes 1, 2 and 3 of that latched value.
- R11: Read data is combinational and valid while the read strobe is high. It is 0x00 while the strobe is low, on unmapped offsets, and in reserved bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per byte write |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 4 | Byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| irq | output | 1 | Interrupt, flag gated by enable |

## Verification
The bench builds the block with its default parameters: a 32-bit count, an 8-bit divide and a 4-bit offset. Because the limit is programmable, limits of three to a few hundred make wrap, halt and repeated matches happen within tens of cycles, while the full 32-bit datapath stays in place. A limit above 0xFFFF makes the upper count bytes non-zero, so the shadow read is tested against carries out of the low byte. A reference model advances the same registers every clock and is compared with the interrupt line and with every read.

// File: rtl/mt_pkg.sv
package mt_pkg;
  // byte offsets of the fixed registers
  localparam int unsigned MODE_OFS = 0;
  localparam int unsigned IEN_OFS  = 1;
  localparam int unsigned FLAG_OFS = 2;
  localparam int unsigned LIM_OFS  = 4;

  typedef struct packed {
    logic single;
    logic repeat_on;
  } mode_t;

  // single-run wins when both bits are written
  function automatic mode_t mode_decode(input logic [1:0] bits);
    mode_t m;
    m.single    = bits[1];
    m.repeat_on = bits[0] & ~bits[1];
    return m;
  endfunction
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q;

  // a step is due once the phase has reached the divide value
  function automatic logic step_due(input logic [DIV_W-1:0] ph, input logic [DIV_W-1:0] dv);
    return ph >= dv;
  endfunction

  assign tick_o = run_i && step_due(pre_q, div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pre_q <= '0;
    else if (restart_i)  pre_q <= '0;
    else if (run_i)      pre_q <= tick_o ? '0 : pre_q + 1'b1;
  end

  // R5
  presc_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_o && !restart_i) |=> (pre_q == $past(pre_q) + 1'b1));
endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic             repeat_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic at_lim, input logic wrap);
    if (!at_lim) return c + 1'b1;
    return wrap ? '0 : c;
  endfunction

  assign hit_o = tick_i && (cnt_q == lim_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= next_count(cnt_q, cnt_q == lim_i, repeat_i);
  end

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && repeat_i && !restart_i) |=> (cnt_q == '0));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/mt_regs.sv
module mt_regs
  import mt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              hit_i,
  output logic              single_o,
  output logic              repeat_o,
  output logic              start_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [CNT_W-1:0]  lim_o,
  output logic              flag_o,
  output logic              ien_o
);
  localparam int NB       = CNT_W / 8;
  localparam int CAP_OFS  = LIM_OFS + NB;
  localparam int DIV_OFS  = CAP_OFS + NB;

  mode_t            mode_q;
  logic             ien_q, flag_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-9:0] shadow_q;

  logic wr_mode, wr_flag, flag_w1c, lim_change, snap, clr_evt;

  function automatic logic at_ofs(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr_mode  = wr_i && at_ofs(addr_i, MODE_OFS);
  assign wr_flag  = wr_i && at_ofs(addr_i, FLAG_OFS);
  assign start_o  = wr_mode && (wdata_i[1] || wdata_i[0]);
  assign flag_w1c = wr_flag && wdata_i[0];
  assign snap     = rd_i && at_ofs(addr_i, CAP_OFS);
  assign clr_evt  = flag_w1c || start_o || lim_change;

  always_comb begin
    lim_change = 1'b0;
    for (int i = 0; i < NB; i++)
      if (wr_i && at_ofs(addr_i, LIM_OFS + i) && (lim_q[8*i +: 8] != wdata_i))
        lim_change = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      ien_q    <= 1'b0;
      flag_q   <= 1'b0;
      div_q    <= '0;
      lim_q    <= '1;
      shadow_q <= '0;
    end else begin
      if (wr_mode)                    mode_q <= mode_decode(wdata_i[1:0]);
      else if (hit_i && mode_q.single) mode_q.single <= 1'b0;
      if (wr_i && at_ofs(addr_i, IEN_OFS)) ien_q <= wdata_i[0];
      if (hit_i)        flag_q <= 1'b1;
      else if (clr_evt) flag_q <= 1'b0;
      if (wr_i && at_ofs(addr_i, DIV_OFS)) div_q <= wdata_i[DIV_W-1:0];
      for (int i = 0; i < NB; i++)
        if (wr_i && at_ofs(addr_i, LIM_OFS + i)) lim_q[8*i +: 8] <= wdata_i;
      if (snap) shadow_q <= cnt_i[CNT_W-1:8];
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (rd_i) begin
      if (at_ofs(addr_i, MODE_OFS)) rdata_o = {6'b0, mode_q.single, mode_q.repeat_on};
      if (at_ofs(addr_i, IEN_OFS))  rdata_o = {7'b0, ien_q};
      if (at_ofs(addr_i, FLAG_OFS)) rdata_o = {7'b0, flag_q};
      if (at_ofs(addr_i, DIV_OFS))  rdata_o = 8'(div_q);
      if (at_ofs(addr_i, CAP_OFS))  rdata_o = cnt_i[7:0];
      for (int i = 0; i < NB; i++)
        if (at_ofs(addr_i, LIM_OFS + i)) rdata_o = lim_q[8*i +: 8];
      for (int i = 1; i < NB; i++)
        if (at_ofs(addr_i, CAP_OFS + i)) rdata_o = shadow_q[8*(i-1) +: 8];
    end
  end

  assign single_o = mode_q.single;
  assign repeat_o = mode_q.repeat_on;
  assign div_o    = div_q;
  assign lim_o    = lim_q;
  assign flag_o   = flag_q;
  assign ien_o    = ien_q;

  // R4
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_q.single && mode_q.repeat_on));
  // R3
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && mode_q.single && !wr_mode) |=> !mode_q.single);
  // R6
  hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> flag_q);
  // R10
  snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (shadow_q == $past(cnt_i[CNT_W-1:8])));
endmodule

// File: rtl/match_timer.sv
module match_timer #(
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);
  logic             single, repeat_on, run, start, tick, hit, flag, ien;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] lim, cnt;

  assign run = single | repeat_on;

  mt_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .rd_i(reg_rd), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .cnt_i(cnt), .hit_i(hit),
    .single_o(single), .repeat_o(repeat_on), .start_o(start), .div_o(div),
    .lim_o(lim), .flag_o(flag), .ien_o(ien)
  );

  mt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(run), .restart_i(start), .div_i(div), .tick_o(tick)
  );

  mt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart_i(start), .run_i(run), .repeat_i(repeat_on),
    .tick_i(tick), .lim_i(lim), .cnt_o(cnt), .hit_o(hit)
  );

  assign irq = flag & ien;

  // R4
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0));
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien |-> !irq) and (irq |-> flag));
endmodule

// File: tb/sim_match_timer.sv
module sim_match_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  match_timer u0 (.clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
                  .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq));

  // behavioural reference state
  bit [31:0] m_cnt, m_lim, m_shadow;
  int        m_pre, m_div;
  bit        m_single, m_rep, m_ien, m_flag;

  task automatic model_reset();
    m_cnt = 0; m_lim = 32'hFFFF_FFFF; m_shadow = 0; m_pre = 0; m_div = 0;
    m_single = 0; m_rep = 0; m_ien = 0; m_flag = 0;
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      bit run, stepping, at, go, chg;
      run = m_single | m_rep;
      stepping = run && (m_pre >= m_div);
      at = stepping && (m_cnt == m_lim);
      go = wr && addr == 0 && wdata[1:0] != 0;
      chg = wr && addr >= 4 && addr <= 7 && m_lim[8*(addr-4) +: 8] != wdata;
      if (rd && addr == 8) m_shadow = m_cnt;
      if (go) begin m_cnt = 0; m_pre = 0; end
      else if (run) begin
        if (stepping) begin
          m_pre = 0;
          if (m_cnt != m_lim) m_cnt = m_cnt + 1;
          else if (m_rep) m_cnt = 0;
        end else m_pre = m_pre + 1;
      end
      if (wr && addr == 0) begin m_single = wdata[1]; m_rep = wdata[0] & ~wdata[1]; end
      else if (at && m_single) m_single = 0;
      if (at) m_flag = 1;
      else if ((wr && addr == 2 && wdata[0]) || go || chg) m_flag = 0;
      if (wr && addr == 1) m_ien = wdata[0];
      if (wr && addr == 12) m_div = wdata;
      if (wr && addr >= 4 && addr <= 7) m_lim[8*(addr-4) +: 8] = wdata;
    end
  end

  function automatic bit [7:0] model_read(input int a);
    case (a)
      0: return {6'b0, m_single, m_rep};
      1: return {7'b0, m_ien};
      2: return {7'b0, m_flag};
      4, 5, 6, 7: return m_lim[8*(a-4) +: 8];
      8: return m_cnt[7:0];
      9, 10, 11: return m_shadow[8*(a-8) +: 8];
      12: return m_div[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-cycle comparison of the interrupt and the idle read bus
  always @(negedge clk) if (rst_n) begin
    check("R9 irq", irq, m_flag & m_ien);
    if (!rd) check("R11 idle rdata", rdata, 0);
  end

  task automatic wr_b(input int a, input int d);
    wr = 1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_b(input string req, input int a);
    rd = 1; addr = 4'(a); #1;
    check(req, rdata, model_read(a));
    @(negedge clk); rd = 0;
  endtask

  task automatic rd_x(input string req, input int a, input int exp);
    rd = 1; addr = 4'(a); #1;
    check(req, rdata, exp);
    @(negedge clk); rd = 0;
  endtask

  task automatic set_lim(input int v);
    for (int i = 0; i < 4; i++) wr_b(4 + i, (v >> (8*i)) & 8'hFF);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values, R11 unmapped offsets
    for (int a = 0; a < 16; a++)
      rd_x("R1 reset map", a, (a >= 4 && a <= 7) ? 8'hFF : 8'h00);
    // R2 repeating mode with limit 3
    set_lim(3);
    wr_b(0, 8'h01);
    for (int i = 0; i < 12; i++) rd_b("R2 repeat count", 8);
    rd_x("R2 mode reads repeat", 0, 8'h01);
    rd_x("R6 flag set after wrap", 2, 8'h01);
    // R9 interrupt enable, R7 clear rules
    wr_b(1, 8'h01); idle(2);
    wr_b(0, 8'h00);                       // stop, count holds (R4)
    rd_b("R4 stop holds count", 8); idle(3); rd_b("R4 stop holds count", 8);
    wr_b(2, 8'h00); rd_x("R7 write 0 keeps flag", 2, 8'h01);
    wr_b(2, 8'h01); rd_x("R7 w1c clears flag", 2, 8'h00);
    // R3 single run
    set_lim(5);
    wr_b(0, 8'h02);
    rd_x("R3 mode reads single", 0, 8'h02);
    idle(20);
    rd_x("R3 halted at limit", 8, 8'h05);
    rd_x("R3 single bit cleared", 0, 8'h00);
    rd_x("R6 flag after single", 2, 8'h01);
    // R8 limit rewrite rules
    wr_b(4, 8'h05); rd_x("R8 same limit keeps flag", 2, 8'h01);
    wr_b(4, 8'h06); rd_x("R8 changed limit clears", 2, 8'h00);
    // R4 exclusivity and start clearing flag
    wr_b(0, 8'h01); idle(10);
    wr_b(0, 8'h03); rd_x("R4 both bits picks single", 0, 8'h02);
    rd_b("R4 restart zeroes", 8);
    idle(12);
    wr_b(0, 8'h01); rd_b("R8 start clears flag", 2);
    // R5 divide
    wr_b(12, 8'h02); set_lim(4); wr_b(0, 8'h01);
    for (int i = 0; i < 20; i++) rd_b("R5 divided count", 8);
    rd_x("R5 divide readback", 12, 8'h02);
    wr_b(12, 8'h00); wr_b(0, 8'h01);
    for (int i = 0; i < 4; i++) rd_b("R5 divide zero", 8);
    // R10 coherent capture with upper bytes moving
    set_lim(32'h0002_0000); wr_b(0, 8'h01);
    idle(700);
    for (int k = 0; k < 3; k++) begin
      rd_b("R10 live low byte", 8);
      rd_b("R10 shadow b1", 9); rd_b("R10 shadow b2", 10); rd_b("R10 shadow b3", 11);
      idle(50);
    end
    rd_x("R10 shadow b1 nonzero", 9, model_read(9));
    check("R10 upper byte moved", (m_shadow[15:8] != 0), 1);
    wr_b(1, 8'h00); idle(2);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule